// File: doc/BRIEF.md
# Ping-Pong Two-Bank Stream Buffer

This block sits between a producer stream and a consumer stream that run at different rates on one clock. Its storage is split into two equal banks that are handed over whole. The write side fills one bank word by word and, once the bank holds its last word, passes it to the read side and moves on to the other bank. The read side sends nothing from a bank until that bank is complete. It empties the bank, hands it back to the write side, and then turns to the other bank. Both sides begin on bank 0 and then alternate.

Both streams use a valid/ready handshake on 64-bit words. A level enable starts and stops transfers. Dropping the enable returns both sides and both ownership flags to idle, with bank 0 first for each side. There are two sticky event flags, each cleared by a write-1 pulse. One marks an overflow: a word was offered but the write target was still owned by the reader. The other marks an underrun: the consumer was ready but no complete bank was available. Bank size is given in bytes and is divided by eight to get the depth in words. Sizes of 16384 and 32768 bytes are both supported.

Top module: `pp_stream_buf`

## Requirements
- R1: After reset, with the enable low, `in_ready`, `out_valid`, `sts_ovf`, `sts_unf` and `irq` are all 0.
- R2: While enabled, words are accepted (`in_valid` and `in_ready` both 1) into bank 0, then bank 1, then bank 0 and so on. A bank switch happens after DEPTH accepted words, where DEPTH = BANK_BYTES/8. `in_ready` is 1 exactly when the current write bank is not held by the reader.
- R3: `out_valid` is 1 only when the current read bank has received all DEPTH of its words. A partly written bank is never presented.
- R4: The reader sends DEPTH words from a bank, then switches to the other bank. The drained bank becomes writable again in the cycle after its last word leaves.
- R5: When enabled with `out_ready` at 1 and `out_valid` at 0, `sts_unf` becomes 1 at the next clock edge and stays 1 until it is cleared.
- R6: When enabled with `in_valid` at 1 and `in_ready` at 0, the word is not stored. `sts_ovf` becomes 1 at the next clock edge and stays 1 until it is cleared.
- R7: A 1 on `clr_ovf` or `clr_unf` clears the matching flag at the next edge. If a new event occurs in the same cycle, the set wins. `irq` is the OR of both flags.
- R8: While the enable is low, `in_ready` and `out_valid` are 0 and no flag is set. A cycle with the enable low empties both banks and points both sides at bank 0. The flags keep their values.
- R9: Words leave in exactly the order they were accepted, with none lost or repeated across bank switches.
- R10: With no reads, exactly 2*DEPTH words are accepted after enable before `in_ready` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Transfer enable; low clears banks and pointers |
| clr_ovf | input | 1 | Write-1 clear for the overflow flag |
| clr_unf | input | 1 | Write-1 clear for the underrun flag |
| in_valid | input | 1 | Producer word valid |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | DW | Producer word |
| out_valid | output | 1 | Word available from a complete bank |
| out_ready | input | 1 | Consumer accepts a word |
| out_data | output | DW | Consumer word |
| sts_ovf | output | 1 | Sticky overflow flag |
| sts_unf | output | 1 | Sticky underrun flag |
| irq | output | 1 | OR of the two flags |

## Verification
The assertions assume a clean, monotonic reset and control inputs that are stable around each clock edge. They also assume the producer does not change `in_data` in a way that depends on `in_ready` within the same cycle. The bench drives every input at the falling edge, so each value is settled well before the active edge. Random traffic is drawn with per-phase valid and ready probabilities. Enable drops and clear pulses are scattered through it, which lets the ownership flags flip in every order, including a set and a clear in the same cycle.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic {
    BANK0 = 1'b0,
    BANK1 = 1'b1
  } bank_e;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int DW    = 64,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/pp_side_ctrl.sv
module pp_side_ctrl
  import pp_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fire,
  output bank_e         bank_o,
  output logic [AW-1:0] ptr_o,
  output logic          last_o
);
  bank_e         bank_q, bank_d;
  logic [AW-1:0] ptr_q, ptr_d;

  assign last_o = (ptr_q == AW'(DEPTH - 1));

  always_comb begin
    bank_d = bank_q;
    ptr_d  = ptr_q;
    if (!en) begin
      bank_d = BANK0;
      ptr_d  = '0;
    end else if (fire) begin
      if (last_o) begin
        ptr_d  = '0;
        bank_d = (bank_q == BANK0) ? BANK1 : BANK0;
      end else begin
        ptr_d = ptr_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= BANK0;
      ptr_q  <= '0;
    end else begin
      bank_q <= bank_d;
      ptr_q  <= ptr_d;
    end
  end

  assign bank_o = bank_q;
  assign ptr_o  = ptr_q;

  AST_SWITCH_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fire && last_o) |=> (bank_q != $past(bank_q)) && (ptr_q == '0)); // R2, R4
  AST_STAY_MID_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !last_o) |=> (bank_q == $past(bank_q))); // R2, R4
endmodule

// File: rtl/pp_stream_buf.sv
module pp_stream_buf
  import pp_pkg::*;
#(
  parameter int DW         = 64,
  parameter int BANK_BYTES = 16384,
  localparam int DEPTH     = BANK_BYTES / (DW / 8),
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          clr_ovf,
  input  logic          clr_unf,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          sts_ovf,
  output logic          sts_unf,
  output logic          irq
);
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  bank_e         wr_bank, rd_bank;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_last, rd_last, in_fire, out_fire;
  logic [1:0]    full_q, full_d;
  logic          ovf_q, ovf_d, unf_q, unf_d, ovf_ev, unf_ev;
  logic [DW-1:0] rdata_b [2];

  assign in_ready  = cfg_en && !full_q[wr_bank];
  assign out_valid = cfg_en && full_q[rd_bank];
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_ready && out_valid;
  assign ovf_ev    = cfg_en && in_valid && !in_ready;
  assign unf_ev    = cfg_en && out_ready && !out_valid;

  pp_side_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_q), .en(cfg_en), .fire(in_fire),
    .bank_o(wr_bank), .ptr_o(wr_ptr), .last_o(wr_last)
  );

  pp_side_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_q), .en(cfg_en), .fire(out_fire),
    .bank_o(rd_bank), .ptr_o(rd_ptr), .last_o(rd_last)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    pp_bank #(.DW(DW), .DEPTH(DEPTH)) u_mem (
      .clk(clk),
      .we(in_fire && (wr_bank == bank_e'(b))),
      .waddr(wr_ptr), .wdata(in_data),
      .raddr(rd_ptr), .rdata(rdata_b[b])
    );

    AST_FULL_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_q)
      $rose(full_q[b]) |-> $past(in_fire && wr_last && (wr_bank == bank_e'(b)))); // R3
    AST_FREE_ONLY_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_q)
      $fell(full_q[b]) |-> $past(!cfg_en || (out_fire && rd_last && (rd_bank == bank_e'(b))))); // R4
  end

  assign out_data = rdata_b[rd_bank];

  always_comb begin
    full_d = full_q;
    if (!cfg_en) begin
      full_d = 2'b00;
    end else begin
      if (in_fire && wr_last)  full_d[wr_bank] = 1'b1;
      if (out_fire && rd_last) full_d[rd_bank] = 1'b0;
    end
    ovf_d = ovf_ev || (ovf_q && !clr_ovf);
    unf_d = unf_ev || (unf_q && !clr_unf);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      full_q <= 2'b00;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
    end
  end

  assign sts_ovf = ovf_q;
  assign sts_unf = unf_q;
  assign irq     = ovf_q || unf_q;

  AST_NO_OVERFLOW_LOST: assert property (@(posedge clk) disable iff (!rst_q)
    (cfg_en && in_valid && !in_ready) |=> sts_ovf); // R6
  AST_UNDERRUN_SEEN: assert property (@(posedge clk) disable iff (!rst_q)
    (cfg_en && out_ready && !out_valid) |=> sts_unf); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_q)
    (clr_ovf && !(cfg_en && in_valid && !in_ready)) |=> !sts_ovf); // R7
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    !cfg_en |=> (full_q == 2'b00) && (wr_ptr == '0) && (rd_ptr == '0)
                && (wr_bank == BANK0) && (rd_bank == BANK0)); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    !cfg_en |-> !in_ready && !out_valid); // R8
endmodule

// File: tb/tb_pp_stream_buf.sv
module tb_pp_stream_buf;
  localparam int DW = 64;
  localparam int BB = 64;
  localparam int D  = BB / (DW / 8);

  logic clk, rst_n, cfg_en, clr_ovf, clr_unf;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [DW-1:0] in_data, out_data;
  logic sts_ovf, sts_unf, irq;

  pp_stream_buf #(.DW(DW), .BANK_BYTES(BB)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .clr_ovf(clr_ovf), .clr_unf(clr_unf),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .sts_ovf(sts_ovf), .sts_unf(sts_unf), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int W = 0, R = 0;
  bit m_ovf = 0, m_unf = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] next_val = 64'hA500_0000_0000_0000;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit pred_ready(input bit en);
    return en && (R >= ((W / D) - 1) * D);
  endfunction

  function automatic bit pred_valid(input bit en);
    return en && (W >= ((R / D) + 1) * D);
  endfunction

  int acc_seen;

  task automatic cyc(input bit iv, input bit ordy, input bit en, input bit cov, input bit cuf);
    bit p_ir, p_ov, ovf_e, unf_e;
    @(negedge clk);
    in_valid = iv; out_ready = ordy; cfg_en = en; clr_ovf = cov; clr_unf = cuf;
    in_data = next_val;
    #1;
    p_ir = pred_ready(en);
    p_ov = pred_valid(en);
    if (in_ready) acc_seen++;
    chk(in_ready == p_ir, "R2 in_ready", DW'(in_ready), DW'(p_ir));
    chk(out_valid == p_ov, "R3 out_valid", DW'(out_valid), DW'(p_ov));
    if (p_ov && exp_q.size() > 0) chk(out_data == exp_q[0], "R9 order", out_data, exp_q[0]);
    chk(sts_ovf == m_ovf, "R6 sts_ovf", DW'(sts_ovf), DW'(m_ovf));
    chk(sts_unf == m_unf, "R5 sts_unf", DW'(sts_unf), DW'(m_unf));
    chk(irq == (m_ovf | m_unf), "R7 irq", DW'(irq), DW'(m_ovf | m_unf));
    ovf_e = en && iv && !p_ir;
    unf_e = en && ordy && !p_ov;
    if (en && iv && p_ir) begin
      exp_q.push_back(next_val);
      next_val++;
      W++;
    end
    if (en && ordy && p_ov) begin
      if (exp_q.size() > 0) void'(exp_q.pop_front());
      R++;
    end
    m_ovf = ovf_e || (m_ovf && !cov);
    m_unf = unf_e || (m_unf && !cuf);
    if (!en) begin
      W = 0; R = 0; exp_q.delete();
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    process::self().srandom(32'd7);
    rst_n = 1'b0; cfg_en = 0; clr_ovf = 0; clr_unf = 0;
    in_valid = 0; out_ready = 0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) cyc(0, 0, 0, 0, 0);
    chk(!in_ready && !out_valid, "R1 handshake idle", DW'({in_ready, out_valid}), 0);
    chk(!sts_ovf && !sts_unf && !irq, "R1 flags idle", DW'({sts_ovf, sts_unf, irq}), 0);

    // R10 / R6: fill both banks with no reads
    acc_seen = 0;
    repeat (2 * D + 3) cyc(1, 0, 1, 0, 0);
    chk(acc_seen == 2 * D, "R10 accepted count", DW'(acc_seen), DW'(2 * D));
    cyc(0, 0, 1, 0, 0);
    chk(sts_ovf == 1'b1, "R6 overflow flag", DW'(sts_ovf), 1);

    // R4: drain bank 0, bank 0 becomes writable, bank 1 readable
    repeat (D) cyc(0, 1, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk(in_ready == 1'b1, "R4 bank released", DW'(in_ready), 1);
    chk(out_valid == 1'b1, "R4 next bank read", DW'(out_valid), 1);

    // R7: plain clear, then set wins against clear
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 1, 0, 0);
    chk(sts_ovf == 1'b0, "R7 clear", DW'(sts_ovf), 0);
    repeat (D) cyc(1, 0, 1, 0, 0);
    cyc(1, 0, 1, 1, 0);
    cyc(0, 0, 1, 0, 0);
    chk(sts_ovf == 1'b1, "R7 set wins", DW'(sts_ovf), 1);

    // R5: drain all, then ask for more
    repeat (2 * D + 2) cyc(0, 1, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk(sts_unf == 1'b1, "R5 underrun flag", DW'(sts_unf), 1);

    // R8: disable mid-bank, flags kept, fresh start at bank 0
    repeat (3) cyc(1, 0, 1, 0, 0);
    cyc(1, 1, 0, 0, 0);
    chk(!in_ready && !out_valid, "R8 quiet when off", DW'({in_ready, out_valid}), 0);
    chk(sts_ovf && sts_unf, "R8 flags kept", DW'({sts_ovf, sts_unf}), 3);
    begin
      logic [DW-1:0] first_w;
      first_w = next_val;
      repeat (D) cyc(1, 0, 1, 1, 1);
      cyc(0, 0, 1, 0, 0);
      chk(out_valid && out_data == first_w, "R8 restart at bank 0", out_data, first_w);
    end

    // R9 / R2 / R4: random traffic
    for (int ph = 0; ph < 8; ph++) begin
      int pv, pr;
      pv = 30 + 10 * (ph % 6);
      pr = 80 - 10 * (ph % 5);
      for (int k = 0; k < 400; k++) begin
        bit en;
        en = ($urandom_range(0, 199) != 0);
        cyc($urandom_range(0, 99) < pv, $urandom_range(0, 99) < pr, en,
            $urandom_range(0, 19) == 0, $urandom_range(0, 19) == 0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule